// File: doc/BRIEF.md
# Three-Frame Temporal Dither Modulator

This block sits between a pixel store and the column drivers of an emissive panel whose red and green sub-pixels can only be switched fully on or off. Each pixel arrives as a 4-bit code holding a 2-bit red level and a 2-bit green level. Every level means off, one third, two thirds or full intensity. The block turns each level into one on/off drive bit per internal scan frame. It steps through a cycle of three scan frames so that, averaged over the cycle, each sub-pixel is lit for as many frames as its level value.

A scan-frame strobe from the panel scan controller advances a phase counter that counts modulo three. This strobe runs at the panel's own refresh rate, which has no relation to the rate at which the host writes pixel data. Green uses the same duty pattern as red, shifted one phase later, so that pixels with equal red and green levels do not load both drivers in the same frames. Results appear one clock after the pixel, and its valid flag travels with them.

Top module: `temporal_dither_mod`

## Requirements
- R1: After reset, drv_valid, drv_red and drv_green are 0 and the frame phase is 0. A pixel presented before any strobe is therefore modulated with phase 0.
- R2: In pix_code, bits [3:2] are the red level (bit 3 most significant) and bits [1:0] are the green level (bit 1 most significant).
- R3: Level 0 never drives its sub-pixel on, and level 3 drives it on in every phase, on both channels.
- R4: Red level 1 is on in phase 0 only. Red level 2 is on in phases 0 and 1 and off in phase 2.
- R5: Green on-phases are red's shifted by one. Green level 1 is on in phase 1 only, and green level 2 is on in phases 1 and 2 and off in phase 0.
- R6: Each cycle with frame_tick high advances the phase by one, going 0, 1, 2, then back to 0. Without frame_tick the phase holds, however many pixels pass.
- R7: drv_valid equals pix_valid delayed by exactly one clock. The drive bits in that cycle belong to the pixel of the previous clock.
- R8: When drv_valid is 0, drv_red and drv_green are 0, whatever pix_code held.
- R9: A pixel presented in the same cycle as frame_tick is modulated with the phase before the advance. The next pixel uses the advanced phase.
- R10: Over three consecutive phases, each channel is driven on in exactly as many phases as its level value (0, 1, 2 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | One-cycle strobe at the start of each internal scan frame |
| pix_valid | input | 1 | pix_code holds a pixel this cycle |
| pix_code | input | 4 | Red level [3:2], green level [1:0] |
| drv_valid | output | 1 | Drive bits are valid |
| drv_red | output | 1 | Red sub-pixel on for this scan frame |
| drv_green | output | 1 | Green sub-pixel on for this scan frame |

## Verification
The only hidden state is the phase counter. A counter that skips, sticks or wraps wrongly shows up as a wrong drive bit on the next valid pixel at level 1 or 2, one clock after that pixel. Levels 0 and 3 hide such a fault. For that reason all 16 codes are swept in every phase, and each strobe is followed by fractional-level pixels. A channel rotation applied to the wrong channel shows up as red and green swapping phases for the same level pair. A wrong phase sampled on a strobe cycle shows up on the pixel that shares the strobe's cycle.

// File: rtl/dither_pkg.sv
`timescale 1ns/1ps
package dither_pkg;
  // number of colour channels and their position in the pixel code
  localparam int unsigned CHANS = 2;
  typedef enum int unsigned {
    CH_RED   = 0,
    CH_GREEN = 1
  } chan_e;
  // register stages of the reset release synchronizer
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/dither_rst_sync.sv
`timescale 1ns/1ps
module dither_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/dither_phase_ctr.sv
`timescale 1ns/1ps
module dither_phase_ctr #(
  parameter int unsigned PERIOD = 3,
  parameter int unsigned PH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;
  logic            phase_en;

  always_comb begin
    phase_en = adv;
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/dither_chan_mod.sv
`timescale 1ns/1ps
module dither_chan_mod #(
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned PERIOD = 3,
  parameter int unsigned PH_W   = 2,
  parameter int unsigned ROT    = 0
) (
  input  logic [PH_W-1:0]  phase,
  input  logic [LVL_W-1:0] level,
  output logic             on
);
  localparam int unsigned SUM_W = PH_W + 1;
  localparam int unsigned ROT_M = ROT % PERIOD;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] lphase;

  // channel-local phase = (phase - ROT) mod PERIOD; on while it is below level
  always_comb begin
    sum = {1'b0, phase} + SUM_W'(PERIOD - ROT_M);
    if (sum >= SUM_W'(PERIOD)) lphase = sum - SUM_W'(PERIOD);
    else                       lphase = sum;
    on = (32'(lphase) < 32'(level));
  end
endmodule

// File: rtl/temporal_dither_mod.sv
`timescale 1ns/1ps
module temporal_dither_mod
  import dither_pkg::*;
#(
  parameter int unsigned LVL_W    = 2,
  parameter int unsigned ROT_STEP = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic               pix_valid,
  input  logic [2*LVL_W-1:0] pix_code,
  output logic               drv_valid,
  output logic               drv_red,
  output logic               drv_green
);
  localparam int unsigned PERIOD = (1 << LVL_W) - 1;
  localparam int unsigned PH_W   = $clog2(PERIOD);

  logic             rst_s_n;
  logic [PH_W-1:0]  phase_q;
  logic [CHANS-1:0] on_w;
  logic [CHANS-1:0] drv_d;
  logic [CHANS-1:0] drv_q;
  logic             vld_d;
  logic             vld_q;

  dither_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  dither_phase_ctr #(.PERIOD(PERIOD), .PH_W(PH_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_s_n),
    .adv   (frame_tick),
    .phase (phase_q)
  );

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    dither_chan_mod #(
      .LVL_W  (LVL_W),
      .PERIOD (PERIOD),
      .PH_W   (PH_W),
      .ROT    (c * ROT_STEP)
    ) u_mod (
      .phase (phase_q),
      .level (pix_code[(CHANS-c)*LVL_W-1 -: LVL_W]),
      .on    (on_w[c])
    );
  end

  always_comb begin
    vld_d = pix_valid;
    drv_d = pix_valid ? on_w : '0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q <= 1'b0;
      drv_q <= '0;
    end else begin
      vld_q <= vld_d;
      drv_q <= drv_d;
    end
  end

  assign drv_valid = vld_q;
  assign drv_red   = drv_q[CH_RED];
  assign drv_green = drv_q[CH_GREEN];
endmodule

// File: rtl/dither_chk.sv
`timescale 1ns/1ps
module dither_chk #(
  parameter int unsigned LVL_W    = 2,
  parameter int unsigned ROT_STEP = 1
) (
  input logic                                 clk,
  input logic                                 rst_s_n,
  input logic                                 frame_tick,
  input logic                                 pix_valid,
  input logic [2*LVL_W-1:0]                   pix_code,
  input logic [$clog2((1 << LVL_W) - 1)-1:0]  phase,
  input logic                                 drv_valid,
  input logic                                 drv_red,
  input logic                                 drv_green
);
  localparam int unsigned PERIOD = (1 << LVL_W) - 1;
  localparam int unsigned PH_W   = $clog2(PERIOD);
  localparam int unsigned GPH    = ROT_STEP % PERIOD;

  logic [LVL_W-1:0] lvl_r;
  logic [LVL_W-1:0] lvl_g;
  assign lvl_r = pix_code[2*LVL_W-1 -: LVL_W];
  assign lvl_g = pix_code[LVL_W-1:0];

  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    pix_valid |=> drv_valid);
  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pix_valid |=> !drv_valid);
  assert_idle_dark_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !drv_valid |-> (!drv_red && !drv_green));
  assert_off_level_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pix_valid && lvl_r == '0) |=> !drv_red);
  assert_full_level_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pix_valid && lvl_r == '1 && lvl_g == '1) |=> (drv_red && drv_green));
  assert_red_third_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pix_valid && lvl_r == LVL_W'(1)) |=> (drv_red == ($past(phase) == '0)));
  assert_green_third_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pix_valid && lvl_g == LVL_W'(1)) |=> (drv_green == ($past(phase) == PH_W'(GPH))));
  assert_phase_wrap_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frame_tick && phase == PH_W'(PERIOD - 1)) |=> (phase == '0));
  assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frame_tick && phase != PH_W'(PERIOD - 1)) |=> (phase == $past(phase) + 1'b1));
  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !frame_tick |=> $stable(phase));
  assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    32'(phase) < PERIOD);
endmodule

bind temporal_dither_mod dither_chk #(.LVL_W(LVL_W), .ROT_STEP(ROT_STEP)) u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .frame_tick (frame_tick),
  .pix_valid  (pix_valid),
  .pix_code   (pix_code),
  .phase      (phase_q),
  .drv_valid  (drv_valid),
  .drv_red    (drv_red),
  .drv_green  (drv_green)
);

// File: tb/test_temporal_dither_mod.sv
`timescale 1ns/1ps
module test_temporal_dither_mod;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic       pix_valid = 1'b0;
  logic [3:0] pix_code = 4'h0;
  logic       drv_valid, drv_red, drv_green;

  typedef struct {
    logic  v;
    logic  r;
    logic  g;
    string tag;
  } exp_t;

  exp_t  q[$];
  exp_t  mon_e;
  int    checks = 0;
  int    errors = 0;
  int    ph_m = 0;
  bit    done = 1'b0;
  bit    acc_en = 1'b0;
  int    sum_r = 0;
  int    sum_g = 0;

  always #2 clk = ~clk;

  temporal_dither_mod i_temporal_dither_mod (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .pix_valid  (pix_valid),
    .pix_code   (pix_code),
    .drv_valid  (drv_valid),
    .drv_red    (drv_red),
    .drv_green  (drv_green)
  );

  // R4: red duty table per phase
  function automatic logic red_on(input int lvl, input int ph);
    case (lvl)
      0:       return 1'b0;
      1:       return ph == 0;
      2:       return ph != 2;
      default: return 1'b1;
    endcase
  endfunction

  // R5: green duty table, one phase later than red
  function automatic logic green_on(input int lvl, input int ph);
    case (lvl)
      0:       return 1'b0;
      1:       return ph == 1;
      2:       return ph != 0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic v, input logic [3:0] code, input logic tick, input string tag);
    exp_t e;
    @(negedge clk);
    pix_valid  = v;
    pix_code   = code;
    frame_tick = tick;
    e.v   = v;
    e.r   = v && red_on(int'(code[3:2]), ph_m);   // R2: red in [3:2]
    e.g   = v && green_on(int'(code[1:0]), ph_m); // R2: green in [1:0]
    e.tag = tag;
    q.push_back(e);
    if (tick) ph_m = (ph_m + 1) % 3;              // R9: advance after use
  endtask

  // monitor: one register between input and output
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      chk(mon_e.tag, "drv_valid", drv_valid, mon_e.v);
      chk(mon_e.tag, "drv_red", drv_red, mon_e.r);
      chk(mon_e.tag, "drv_green", drv_green, mon_e.g);
      if (acc_en && drv_valid) begin
        sum_r += int'(drv_red);
        sum_g += int'(drv_green);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "drv_valid in reset", drv_valid, 1'b0);
    chk("R1", "drv_red in reset", drv_red, 1'b0);
    chk("R1", "drv_green in reset", drv_green, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "drv_valid after release", drv_valid, 1'b0);

    // R1: first pixel uses phase 0 (red level 1 on, green level 1 off)
    step(1'b1, 4'b0101, 1'b0, "R1");
    step(1'b1, 4'b1010, 1'b0, "R1");

    // R2 R3 R4 R5: every code in every phase
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 16; c++) step(1'b1, 4'(c), 1'b0, "R2/R3/R4/R5 sweep");
      step(1'b0, 4'h0, 1'b1, "R6 tick");
    end

    // R8: invalid cycles with non-zero codes stay dark
    step(1'b0, 4'hF, 1'b0, "R8");
    step(1'b0, 4'hA, 1'b0, "R8");

    // R9: pixel sharing the strobe cycle uses the old phase
    step(1'b1, 4'b0101, 1'b1, "R9");
    step(1'b1, 4'b0101, 1'b0, "R9");
    step(1'b1, 4'b1010, 1'b1, "R9");
    step(1'b1, 4'b1010, 1'b0, "R9");

    // R6: several strobes with no pixels, then probe the phase
    for (int k = 0; k < 4; k++) step(1'b0, 4'h0, 1'b1, "R6");
    step(1'b1, 4'b0101, 1'b0, "R6");
    step(1'b1, 4'b1001, 1'b0, "R6");

    // R7: irregular valid pattern
    step(1'b1, 4'b0110, 1'b0, "R7");
    step(1'b0, 4'b0110, 1'b0, "R7");
    step(1'b1, 4'b1101, 1'b0, "R7");
    step(1'b1, 4'b0111, 1'b0, "R7");
    step(1'b0, 4'b1111, 1'b0, "R7");

    // R10: duty over three consecutive phases equals the level
    for (int l = 0; l < 4; l++) begin
      @(negedge clk);
      sum_r  = 0;
      sum_g  = 0;
      acc_en = 1'b1;
      for (int k = 0; k < 3; k++) step(1'b1, {2'(l), 2'(3 - l)}, 1'b1, "R10");
      step(1'b0, 4'h0, 1'b0, "R10");
      @(posedge clk);
      #2;
      chk_int("R10", "red on-count", sum_r, l);
      chk_int("R10", "green on-count", sum_g, 3 - l);
      acc_en = 1'b0;
    end

    step(1'b0, 4'h0, 1'b0, "R8");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule